// File: doc/BRIEF.md
# FIFO Offset Register Load Port

This block sits beside a synchronous FIFO and owns the two offset values that the programmable almost-empty and almost-full flags compare against. It reuses the FIFO's own data buses and strobes. While the active-low load input is high, the write and read strobes pass straight through to the FIFO memory, and the output bus carries the FIFO's read data. While load is low, both FIFO strobes are forced inactive. The strobes then act on the offset registers.

In load mode, each write-clock edge with write enable low stores the input bus into the offset register chosen by a write selector, and that selector then steps on. Each read-clock edge with read enable low copies the register chosen by a separate read selector into a readback register, and that selector steps on. The readback register drives the output bus while load is low. Readback works only in standard mode. It is frozen when the fall-through mode bit is set. The two offsets are always presented to the flag logic on dedicated outputs.

Each selector is a two-state machine with states `SEL_EMPTY` (index 0) and `SEL_FULL` (index 1). It has one named transition, `STEP`, which goes from `SEL_EMPTY` to `SEL_FULL` and wraps from `SEL_FULL` back to `SEL_EMPTY`. It has one named hold, `STAY`, taken on every edge without a qualifying strobe. Both machines enter `SEL_EMPTY` on reset.

Top module: `fifo_ofs_port`

## Requirements
- R1: With ld_n=0 and wen_n=0, a wclk rising edge stores din into the offset register picked by the write selector. The selector then steps: the empty offset is written first, then the full offset, and then it wraps back to the empty offset.
- R2: With ld_n=0 and wen_n=1, a wclk edge changes neither offset register nor the write selector.
- R3: With ld_n=0, ren_n=0, wen_n=1 and fall_thru=0, an rclk rising edge loads the readback register with the offset picked by the read selector. The read selector then steps: empty first, then full, then it wraps. The read selector moves independently of the write selector.
- R4: With fall_thru=1, rclk edges leave the readback register and the read selector unchanged.
- R5: When ld_n=0, ren_n=0 and wen_n=0 hold together at an rclk edge, the write proceeds. The readback register and the read selector hold.
- R6: After reset, both selectors point at the empty offset, empty_ofs equals EMPTY_DEF (default 127), full_ofs equals FULL_DEF (default 127), and the readback register is 0.
- R7: With ld_n=1, fifo_wen_n follows wen_n, fifo_ren_n follows ren_n, and the offsets hold. With ld_n=0, both FIFO strobes are 1.
- R8: q equals fifo_q when ld_n=1 and equals the readback register when ld_n=0.
- R9: empty_ofs and full_ofs always show the current contents of the two offset registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low offset access select |
| wen_n | input | 1 | Active-low write strobe |
| ren_n | input | 1 | Active-low read strobe |
| fall_thru | input | 1 | 1 = fall-through mode, 0 = standard mode |
| din | input | DW | Shared input data bus |
| fifo_q | input | DW | Read data from the FIFO memory |
| q | output | DW | Shared output data bus |
| fifo_wen_n | output | 1 | Write strobe to the FIFO memory |
| fifo_ren_n | output | 1 | Read strobe to the FIFO memory |
| empty_ofs | output | DW | Almost-empty offset to the flag logic |
| full_ofs | output | DW | Almost-full offset to the flag logic |

## Verification
The assertions assume that the inputs are settled well away from the clock edges. The conflict rule (R5) also assumes that ld_n, wen_n and ren_n are sampled consistently in both clock domains. The bench meets these assumptions by driving both clocks from one 125 MHz source and by changing every input on the falling edge. Its random phase draws load, strobe and mode values from a seeded generator, so it lands on simultaneous read/write requests and fall-through edges often. Directed sequences then cover the selector wrap, the reset defaults and the pass-through paths.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
    localparam int unsigned NUM_OFS = 2;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e sel_step(input ofs_sel_e cur);
        ofs_sel_e nxt;
        unique case (cur)
            SEL_EMPTY: nxt = SEL_FULL;
            SEL_FULL:  nxt = SEL_EMPTY;
            default:   nxt = SEL_EMPTY;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/ofs_strobe_steer.sv
module ofs_strobe_steer (
    input  logic ld_n,
    input  logic wen_n,
    input  logic ren_n,
    output logic fifo_wen_n,
    output logic fifo_ren_n,
    output logic ofs_wr_req,
    output logic ofs_rd_req
);
    always_comb begin
        if (ld_n) begin
            fifo_wen_n = wen_n;
            fifo_ren_n = ren_n;
            ofs_wr_req = 1'b0;
            ofs_rd_req = 1'b0;
        end else begin
            fifo_wen_n = 1'b1;
            fifo_ren_n = 1'b1;
            ofs_wr_req = ~wen_n;
            ofs_rd_req = ~ren_n;
        end
    end
endmodule

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
    import fifo_ofs_pkg::*;
#(
    parameter int unsigned DW        = 18,
    parameter logic [DW-1:0] EMPTY_DEF = 127,
    parameter logic [DW-1:0] FULL_DEF  = 127
) (
    input  logic                        wclk,
    input  logic                        rst_n,
    input  logic                        wr_req,
    input  logic [DW-1:0]               din,
    output logic [NUM_OFS-1:0][DW-1:0]  bank
);
    ofs_sel_e wsel, wsel_nxt;
    logic [NUM_OFS-1:0] wr_hit;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wsel <= SEL_EMPTY;
        else        wsel <= wsel_nxt;
    end

    always_comb begin
        wsel_nxt = wsel;
        unique case (wsel)
            SEL_EMPTY: if (wr_req) wsel_nxt = sel_step(SEL_EMPTY);
            SEL_FULL:  if (wr_req) wsel_nxt = sel_step(SEL_FULL);
            default:   wsel_nxt = SEL_EMPTY;
        endcase
    end

    for (genvar i = 0; i < NUM_OFS; i++) begin : g_reg
        localparam logic [DW-1:0] DEF = (i == 0) ? EMPTY_DEF : FULL_DEF;
        assign wr_hit[i] = wr_req && (int'(wsel) == i);
        always_ff @(posedge wclk or negedge rst_n) begin
            if (!rst_n)         bank[i] <= DEF;
            else if (wr_hit[i]) bank[i] <= din;
        end
    end

    a_r2_idle_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_req |=> $stable(bank) && $stable(wsel));
    a_r1_step: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_req |=> wsel != $past(wsel));
    a_r1_empty_first: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && wsel == SEL_EMPTY) |=> bank[0] == $past(din) && $stable(bank[1]));
endmodule

// File: rtl/ofs_rd_ctrl.sv
module ofs_rd_ctrl
    import fifo_ofs_pkg::*;
#(
    parameter int unsigned DW = 18
) (
    input  logic                        rclk,
    input  logic                        rst_n,
    input  logic                        rd_req,
    input  logic                        wr_req,
    input  logic                        fall_thru,
    input  logic [NUM_OFS-1:0][DW-1:0]  bank,
    output logic [DW-1:0]               rd_q
);
    ofs_sel_e rsel, rsel_nxt;
    logic     rd_go;

    assign rd_go = rd_req && !wr_req && !fall_thru;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rsel <= SEL_EMPTY;
        else        rsel <= rsel_nxt;
    end

    always_comb begin
        rsel_nxt = rsel;
        unique case (rsel)
            SEL_EMPTY: if (rd_go) rsel_nxt = sel_step(SEL_EMPTY);
            SEL_FULL:  if (rd_go) rsel_nxt = sel_step(SEL_FULL);
            default:   rsel_nxt = SEL_EMPTY;
        endcase
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_go) rd_q <= bank[rsel];
    end

    a_r4_fwft_freeze: assert property (@(posedge rclk) disable iff (!rst_n)
        fall_thru |=> $stable(rd_q) && $stable(rsel));
    a_r5_write_wins: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_req && wr_req) |=> $stable(rd_q) && $stable(rsel));
    a_r3_step: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_req && !wr_req && !fall_thru) |=> rsel != $past(rsel));
endmodule

// File: rtl/fifo_ofs_port.sv
module fifo_ofs_port
    import fifo_ofs_pkg::*;
#(
    parameter int unsigned   DW        = 18,
    parameter logic [DW-1:0] EMPTY_DEF = 127,
    parameter logic [DW-1:0] FULL_DEF  = 127
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          wen_n,
    input  logic          ren_n,
    input  logic          fall_thru,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] fifo_q,
    output logic [DW-1:0] q,
    output logic          fifo_wen_n,
    output logic          fifo_ren_n,
    output logic [DW-1:0] empty_ofs,
    output logic [DW-1:0] full_ofs
);
    logic                       wr_req, rd_req;
    logic [NUM_OFS-1:0][DW-1:0] bank;
    logic [DW-1:0]              rd_q;

    ofs_strobe_steer u_steer (
        .ld_n       (ld_n),
        .wen_n      (wen_n),
        .ren_n      (ren_n),
        .fifo_wen_n (fifo_wen_n),
        .fifo_ren_n (fifo_ren_n),
        .ofs_wr_req (wr_req),
        .ofs_rd_req (rd_req)
    );

    ofs_wr_ctrl #(.DW(DW), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)) u_wr (
        .wclk   (wclk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .din    (din),
        .bank   (bank)
    );

    ofs_rd_ctrl #(.DW(DW)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .fall_thru (fall_thru),
        .bank      (bank),
        .rd_q      (rd_q)
    );

    assign empty_ofs = bank[0];
    assign full_ofs  = bank[1];
    assign q         = ld_n ? fifo_q : rd_q;

    a_r7_offsets_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        ld_n |=> $stable(empty_ofs) && $stable(full_ofs));
    always_comb begin
        if (rst_n && ld_n === 1'b0)
            a_r7_fifo_blocked: assert (fifo_wen_n && fifo_ren_n);
    end
endmodule

// File: tb/fifo_ofs_port_bench.sv
module fifo_ofs_port_bench;
    localparam int unsigned DW = 18;
    localparam logic [DW-1:0] DEF = 127;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1, fall_thru = 1'b0;
    logic [DW-1:0] din = '0, fifo_q = '0;
    logic [DW-1:0] q, empty_ofs, full_ofs;
    logic fifo_wen_n, fifo_ren_n;

    int checks = 0, fails = 0;
    logic [DW-1:0] m_reg [2];
    int m_wsel = 0, m_rsel = 0;
    logic [DW-1:0] m_q = '0;

    always #4 clk = ~clk;

    fifo_ofs_port u_fifo_ofs_port (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
        .ren_n(ren_n), .fall_thru(fall_thru), .din(din), .fifo_q(fifo_q),
        .q(q), .fifo_wen_n(fifo_wen_n), .fifo_ren_n(fifo_ren_n),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_fifo_w(input logic l, input logic w);
        return l ? w : 1'b1;
    endfunction

    task automatic cyc(input logic l, input logic w, input logic r, input logic ft,
                       input logic [DW-1:0] d, input logic [DW-1:0] fq);
        logic rd_go;
        @(negedge clk);
        ld_n = l; wen_n = w; ren_n = r; fall_thru = ft; din = d; fifo_q = fq;
        #1;
        chk("R7 wen", {{(DW-1){1'b0}}, fifo_wen_n}, {{(DW-1){1'b0}}, exp_fifo_w(l, w)});
        chk("R7 ren", {{(DW-1){1'b0}}, fifo_ren_n}, {{(DW-1){1'b0}}, exp_fifo_w(l, r)});
        @(posedge clk);
        rd_go = !l && !r && w && !ft;
        if (rd_go) begin
            m_q = m_reg[m_rsel];
            m_rsel = 1 - m_rsel;
        end
        if (!l && !w) begin
            m_reg[m_wsel] = d;
            m_wsel = 1 - m_wsel;
        end
        #1;
        chk("R9 empty_ofs", empty_ofs, m_reg[0]);
        chk("R9 full_ofs", full_ofs, m_reg[1]);
        chk("R8 q", q, l ? fq : m_q);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        m_reg[0] = DEF; m_reg[1] = DEF;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset defaults and readback register cleared
        ld_n = 1'b0; #1;
        chk("R6 empty default", empty_ofs, DEF);
        chk("R6 full default", full_ofs, DEF);
        chk("R6 readback zero", q, '0);
        // R1: empty written first, then full, then wrap
        cyc(0, 0, 1, 0, 18'h00011, 18'h3);
        chk("R1 empty first", empty_ofs, 18'h00011);
        cyc(0, 0, 1, 0, 18'h00022, 18'h3);
        chk("R1 full second", full_ofs, 18'h00022);
        cyc(0, 0, 1, 0, 18'h00033, 18'h3);
        chk("R1 wrap to empty", empty_ofs, 18'h00033);
        // R2: wen high in load mode ignored
        cyc(0, 1, 1, 0, 18'h3ffff, 18'h3);
        chk("R2 full untouched", full_ofs, 18'h00022);
        // R3: readback empty then full then wrap (read selector independent)
        cyc(0, 1, 0, 0, 18'h0, 18'h3);
        chk("R3 read empty", q, 18'h00033);
        cyc(0, 1, 0, 0, 18'h0, 18'h3);
        chk("R3 read full", q, 18'h00022);
        cyc(0, 1, 0, 0, 18'h0, 18'h3);
        chk("R3 read wrap", q, 18'h00033);
        // R4: fall-through freezes readback
        cyc(0, 1, 0, 1, 18'h0, 18'h3);
        chk("R4 fwft hold", q, 18'h00033);
        // R5: simultaneous read and write, write wins
        cyc(0, 0, 0, 0, 18'h00044, 18'h3);
        chk("R5 write done", full_ofs, 18'h00044);
        chk("R5 q held", q, 18'h00033);
        // R7/R8: pass-through with load high
        cyc(1, 0, 0, 0, 18'h00055, 18'h2abcd);
        chk("R7 offsets hold", empty_ofs, 18'h00033);
        chk("R8 fifo data", q, 18'h2abcd);
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [3:0] rb;
            rb = 4'($urandom);
            cyc(rb[0] & rb[3], rb[1], rb[2], ($urandom % 5) == 0,
                DW'($urandom), DW'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule